// File: doc/BRIEF.md
# Indexed Mailbox Command Responder

This block sits behind a pair of adjacent byte ports. The host first writes an index byte to port 0. It then reads or writes the data byte at that index through port 1. Behind the ports is a small window of byte registers. Three of them have a role:

- a command register at 0x80;
- a response register at 0x82;
- an ownership-flag register at 0x83.

The remaining registers in the window are plain storage.

The host hands bus ownership back and forth in three steps:

1. It clears the response register and writes the desired flag value into the ownership register.
2. It writes the kick command 0x96 into the command register.
3. It polls the response register until it reads the completion byte 0xFA.

The block holds the response register unchanged for a configurable number of cycles. It then posts 0xFA and applies the ownership flag that was in place at the kick to the `hostOwned` output.

Top module: `mbox_responder`

## Requirements
- R1: A write to port 0 (`portAddr`=0) loads the index register. A write to port 1 stores `wrData` into the register the index selects. A read of port 1 returns that register, and a read of port 0 returns the index itself. The read data is combinational from the current state.
- R2: The register window covers the `NUM_REGS` indices starting at `REG_BASE` (0x80..0x87 by default). Port-1 reads at any other index return 0x00. Port-1 writes at any other index change no register.
- R3: After reset, every window register, the index and `hostOwned` are all zero.
- R4: A port-1 write of 0x96 while the index is 0x80 and no sequence is running starts a sequence. Exactly `LATENCY` clock edges after the edge that took the write, register 0x82 reads 0xFA.
- R5: While a sequence runs, register 0x82 shows the value the host last wrote to it, including writes made during the delay.
- R6: At completion, a flag value of 0xB4 sets `hostOwned` and a flag value of 0xB5 clears it. The change appears on the same edge on which 0xFA is posted.
- R7: At completion, any other flag value leaves `hostOwned` unchanged, and 0xFA is still posted.
- R8: The flag value is captured at the kick. Rewriting register 0x83 during the delay does not change the outcome.
- R9: Any other value written to 0x80 is stored and reads back. It starts no sequence, posts no response and leaves `hostOwned` as it was.
- R10: A kick written while a sequence is already running is ignored. The pending completion keeps its original timing.
- R11: If a host write to 0x82 lands on the completion edge, the completion byte 0xFA wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| portAddr | input | 1 | Port select: 0 = index port, 1 = data port |
| wrEn | input | 1 | Write strobe for the selected port |
| wrData | input | 8 | Write data byte |
| rdData | output | 8 | Read data of the selected port (combinational) |
| hostOwned | output | 1 | Host currently holds bus ownership |

## Verification
The handshake is exercised with several flag values:

- the take value 0xB4;
- the release value 0xB5;
- an unrelated value, to tell the set, clear and hold outcomes apart.

One run rewrites the flag mid-delay to show that the value captured at the kick decides the outcome.

The response register is sampled one cycle before and exactly on the completion edge, which pins the latency to the cycle. A second kick during the delay distinguishes "ignore" from "restart". A host write that collides with the completion edge shows which source has priority.

Two further patterns cover the decoder and the window edge:

- a non-kick command, to show that decoding the command value matters;
- accesses just outside the window.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  localparam logic [7:0] IDX_CMD   = 8'h80;
  localparam logic [7:0] IDX_RESP  = 8'h82;
  localparam logic [7:0] IDX_OWN   = 8'h83;
  localparam logic [7:0] CMD_KICK  = 8'h96;
  localparam logic [7:0] OWN_TAKE  = 8'hB4;
  localparam logic [7:0] OWN_GIVE  = 8'hB5;
  localparam logic [7:0] RESP_DONE = 8'hFA;

  // Strobes from sequencer to register datapath
  typedef struct packed {
    logic latchOwn;   // capture ownership flag (accepted kick)
    logic postDone;   // post completion code and apply flag
  } mboxStrb_t;

  typedef enum logic {S_IDLE, S_WAIT} seqState_t;

endpackage

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
#(
  parameter int LATENCY = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      kickSeen,
  output mboxStrb_t strb
);

  localparam int CNT_W = $clog2(LATENCY + 1);

  seqState_t  state;
  logic [CNT_W-1:0] cnt;
  logic accept;
  logic lastTick;

  assign accept   = (state == S_IDLE) && kickSeen;
  assign lastTick = (state == S_WAIT) && (cnt == CNT_W'(1));

  always_comb begin
    strb          = '0;
    strb.latchOwn = accept;
    strb.postDone = lastTick;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        S_IDLE: if (kickSeen) begin
          state <= S_WAIT;
          cnt   <= CNT_W'(LATENCY);
        end
        S_WAIT: begin
          if (cnt == CNT_W'(1)) begin
            state <= S_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R4
  kick_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && kickSeen) |=> (state == S_WAIT && cnt == CNT_W'(LATENCY)));

  // R4
  wait_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_WAIT) |-> (cnt != '0));

  // R10
  busy_kick_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_WAIT && cnt != CNT_W'(1) && kickSeen) |=> (cnt == $past(cnt) - CNT_W'(1)));

endmodule

// File: rtl/mbox_regs.sv
module mbox_regs
  import mbox_pkg::*;
#(
  parameter logic [7:0] REG_BASE = 8'h80,
  parameter int         NUM_REGS = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       portAddr,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  input  mboxStrb_t  strb,
  output logic       kickSeen,
  output logic [7:0] rdData,
  output logic       hostOwned
);

  localparam int OFF_W    = $clog2(NUM_REGS);
  localparam int RESP_OFF = int'(IDX_RESP - REG_BASE);
  localparam int OWN_OFF  = int'(IDX_OWN - REG_BASE);

  logic [7:0] idxQ;
  logic [7:0] offFull;
  logic       hit;
  logic       dataWr;
  logic [7:0] pendOwn;
  logic [7:0] regQ [NUM_REGS];

  assign dataWr  = wrEn && portAddr;
  assign offFull = idxQ - REG_BASE;
  assign hit     = offFull < 8'(NUM_REGS);
  assign kickSeen = dataWr && (idxQ == IDX_CMD) && (wrData == CMD_KICK);

  always_ff @(posedge clk) begin
    if (!rstN)                idxQ <= '0;
    else if (wrEn && !portAddr) idxQ <= wrData;
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : gReg
    logic [7:0] q;
    logic hostWr;
    assign hostWr = dataWr && hit && (offFull == 8'(g));
    if (g == RESP_OFF) begin : gResp
      always_ff @(posedge clk) begin
        if (!rstN)              q <= '0;
        else if (strb.postDone) q <= RESP_DONE;
        else if (hostWr)        q <= wrData;
      end
    end else begin : gPlain
      always_ff @(posedge clk) begin
        if (!rstN)       q <= '0;
        else if (hostWr) q <= wrData;
      end
    end
    assign regQ[g] = q;
  end

  always_comb begin
    if (!portAddr) rdData = idxQ;
    else if (hit)  rdData = regQ[offFull[OFF_W-1:0]];
    else           rdData = 8'h00;
  end

  always_ff @(posedge clk) begin
    if (!rstN)              pendOwn <= '0;
    else if (strb.latchOwn) pendOwn <= regQ[OWN_OFF];
  end

  always_ff @(posedge clk) begin
    if (!rstN) hostOwned <= 1'b0;
    else if (strb.postDone) begin
      if (pendOwn == OWN_TAKE)      hostOwned <= 1'b1;
      else if (pendOwn == OWN_GIVE) hostOwned <= 1'b0;
    end
  end

  // R6
  own_take_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.postDone && pendOwn == OWN_TAKE) |=> hostOwned);

  // R6
  own_give_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.postDone && pendOwn == OWN_GIVE) |=> !hostOwned);

  // R7
  own_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.postDone) |=> $stable(hostOwned));

  // R11
  done_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.postDone |=> (regQ[RESP_OFF] == RESP_DONE));

endmodule

// File: rtl/mbox_responder.sv
module mbox_responder
  import mbox_pkg::*;
#(
  parameter int         LATENCY  = 16,
  parameter logic [7:0] REG_BASE = 8'h80,
  parameter int         NUM_REGS = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       portAddr,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  output logic       hostOwned
);

  mboxStrb_t strb;
  logic      kickSeen;

  mbox_ctrl #(.LATENCY(LATENCY)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .kickSeen (kickSeen),
    .strb     (strb)
  );

  mbox_regs #(.REG_BASE(REG_BASE), .NUM_REGS(NUM_REGS)) uRegs (
    .clk       (clk),
    .rstN      (rstN),
    .portAddr  (portAddr),
    .wrEn      (wrEn),
    .wrData    (wrData),
    .strb      (strb),
    .kickSeen  (kickSeen),
    .rdData    (rdData),
    .hostOwned (hostOwned)
  );

endmodule

// File: tb/tb_mbox_responder.sv
`timescale 1ns/1ps
module tb_mbox_responder;

  localparam int LAT = 12;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       portAddr = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic       hostOwned;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  mbox_responder #(.LATENCY(LAT)) dut (
    .clk(clk), .rstN(rstN), .portAddr(portAddr), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdData), .hostOwned(hostOwned)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // called at a negedge; consumes exactly one rising edge
  task automatic wr(input logic p, input logic [7:0] d);
    portAddr = p; wrData = d; wrEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic setReg(input logic [7:0] idx, input logic [7:0] val);
    wr(1'b0, idx);
    wr(1'b1, val);
  endtask

  task automatic peek(input logic p, output logic [7:0] v);
    portAddr = p;
    #1;
    v = rdData;
  endtask

  task automatic readReg(input logic [7:0] idx, output logic [7:0] v);
    wr(1'b0, idx);
    peek(1'b1, v);
  endtask

  task automatic kickAndWait(input logic [7:0] flag);
    setReg(8'h82, 8'h00);
    setReg(8'h83, flag);
    setReg(8'h80, 8'h96);
    repeat (LAT + 1) @(negedge clk);
  endtask

  task automatic tReset();
    logic [7:0] v;
    peek(1'b0, v);  chk("R3 index", v, 8'h00);
    chk("R3 owned", {7'b0, hostOwned}, 8'h00);
    readReg(8'h83, v); chk("R3 flag reg", v, 8'h00);
    readReg(8'h82, v); chk("R3 resp reg", v, 8'h00);
  endtask

  task automatic tIndexData();
    logic [7:0] v;
    wr(1'b0, 8'h81);
    peek(1'b0, v); chk("R1 index readback", v, 8'h81);
    wr(1'b1, 8'hC3);
    peek(1'b1, v); chk("R1 data readback", v, 8'hC3);
    setReg(8'h87, 8'h3C);
    readReg(8'h87, v); chk("R1 top of window", v, 8'h3C);
  endtask

  task automatic tWindow();
    logic [7:0] v;
    setReg(8'h40, 8'h55);
    peek(1'b1, v); chk("R2 low outside read", v, 8'h00);
    setReg(8'h88, 8'hAA);
    peek(1'b1, v); chk("R2 high outside read", v, 8'h00);
    setReg(8'h7F, 8'h99);
    readReg(8'h87, v); chk("R2 neighbour untouched", v, 8'h3C);
    readReg(8'h80, v); chk("R2 base untouched", v, 8'h00);
  endtask

  task automatic tTake();
    logic [7:0] v;
    setReg(8'h82, 8'h00);
    setReg(8'h83, 8'hB4);
    setReg(8'h80, 8'h96);              // kick edge E, k=0
    wr(1'b0, 8'h82);                   // k=1
    wr(1'b1, 8'h5A);                   // k=2, host write during delay
    repeat (LAT - 3) @(negedge clk);   // k=LAT-1
    peek(1'b1, v); chk("R5 resp held before done", v, 8'h5A);
    chk("R4 owned before done", {7'b0, hostOwned}, 8'h00);
    @(negedge clk);                    // k=LAT
    peek(1'b1, v); chk("R4 resp on done edge", v, 8'hFA);
    chk("R6 take sets owned", {7'b0, hostOwned}, 8'h01);
  endtask

  task automatic tOther();
    logic [7:0] v;
    kickAndWait(8'h11);
    readReg(8'h82, v); chk("R7 resp posted", v, 8'hFA);
    chk("R7 owned unchanged", {7'b0, hostOwned}, 8'h01);
  endtask

  task automatic tUnknown();
    logic [7:0] v;
    setReg(8'h82, 8'h00);
    setReg(8'h83, 8'hB5);
    setReg(8'h80, 8'h42);
    repeat (LAT + 4) @(negedge clk);
    readReg(8'h82, v); chk("R9 no response", v, 8'h00);
    chk("R9 owned unchanged", {7'b0, hostOwned}, 8'h01);
    readReg(8'h80, v); chk("R9 command stored", v, 8'h42);
  endtask

  task automatic tGive();
    logic [7:0] v;
    kickAndWait(8'hB5);
    readReg(8'h82, v); chk("R6 give resp", v, 8'hFA);
    chk("R6 give clears owned", {7'b0, hostOwned}, 8'h00);
  endtask

  task automatic tSampleAtKick();
    setReg(8'h82, 8'h00);
    setReg(8'h83, 8'hB4);
    setReg(8'h80, 8'h96);              // k=0
    setReg(8'h83, 8'hB5);              // k=2, rewrite mid-delay
    repeat (LAT) @(negedge clk);
    chk("R8 flag captured at kick", {7'b0, hostOwned}, 8'h01);
  endtask

  task automatic tBusyKick();
    logic [7:0] v;
    setReg(8'h82, 8'h00);
    setReg(8'h83, 8'hB5);
    setReg(8'h80, 8'h96);              // k=0, index stays 0x80
    repeat (3) @(negedge clk);         // k=3
    wr(1'b1, 8'h96);                   // k=4, second kick
    wr(1'b0, 8'h82);                   // k=5
    repeat (LAT - 6) @(negedge clk);   // k=LAT-1
    peek(1'b1, v); chk("R10 not done early", v, 8'h00);
    @(negedge clk);                    // k=LAT
    peek(1'b1, v); chk("R10 original timing kept", v, 8'hFA);
    chk("R10 give applied", {7'b0, hostOwned}, 8'h00);
  endtask

  task automatic tCollide();
    logic [7:0] v;
    setReg(8'h82, 8'h00);
    setReg(8'h83, 8'hB4);
    setReg(8'h80, 8'h96);              // k=0
    wr(1'b0, 8'h82);                   // k=1
    repeat (LAT - 2) @(negedge clk);   // k=LAT-1
    wr(1'b1, 8'h33);                   // lands on edge k=LAT
    peek(1'b1, v); chk("R11 completion wins", v, 8'hFA);
    wr(1'b1, 8'h33);
    peek(1'b1, v); chk("R11 later write accepted", v, 8'h33);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tIndexData();
    tWindow();
    tTake();
    tOther();
    tUnknown();
    tGive();
    tSampleAtKick();
    tBusyKick();
    tCollide();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule